// File: doc/BRIEF.md
# Per-Flow Learn Request Throttle

This block sits on the receive path of a flow offload engine. Each packet that missed the flow table arrives with a hash index, and the block decides whether a learn request for that index should be passed on. Every index owns a 16-bit timestamp. A request for an index goes out only when enough time has passed since the last request for that same index; otherwise it is dropped. One index that is seen often therefore cannot flood the learning logic, and other indices are not slowed down by it.

Time comes from a free-running counter. The counter advances on each cycle where the tick input is high, and only its low 16 bits are used. The minimum interval is one tenth of the tick rate. The tick rate is a parameter; the default of 1000 ticks per second gives a 100-tick interval. The timestamp store is cleared to zero by reset. Because of that, an index is not forwarded for the first time until the counter has reached the interval. Requests leave through a valid/ready stream. A one-deep skid buffer holds a request while the consumer stalls, and input ready drops once that buffer is occupied.

Top module: `flow_learn_throttle`

## Requirements
- R1: After reset `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: An accepted hash greater than DEPTH-1 produces no request and changes no timestamp. A later in-range hash behaves as if the out-of-range one had never arrived.
- R3: The current time is the low 16 bits of a counter that is cleared by reset and increments once for each clock edge at which `tick_i` is high.
- R4: If (now - stamp[idx]) mod 2^16 is less than THRESH = TICK_RATE/10, the packet is dropped and stamp[idx] keeps its value. With the defaults, an elapsed time of 99 drops and 100 passes.
- R5: Otherwise the block emits a request carrying `idx` and sets stamp[idx] to now. An immediate repeat of the same index then drops.
- R6: Reset clears every timestamp to zero. The first packet for any index passes only when now >= THRESH.
- R7: The elapsed time is computed modulo 2^16, so the decision stays correct after the counter wraps past 65535.
- R8: When two packets with the same index are accepted on consecutive cycles, the second one sees the timestamp written by the first and is dropped.
- R9: A request becomes valid on `out_valid_o` exactly two clock edges after its packet is accepted. Requests leave in the order their packets were accepted.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_idx_o` holds steady. One more request may wait in the skid buffer; once it is filled, `in_ready_o` is 0 until the output drains. No request is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time base pulse; advances the counter by one |
| in_valid_i | input | 1 | Missed-packet hash is present |
| in_hash_i | input | HASH_W | Flow hash index of the packet |
| in_ready_o | output | 1 | Block can take a hash this cycle |
| out_valid_o | output | 1 | Learn request is present |
| out_ready_i | input | 1 | Consumer takes the learn request |
| out_idx_o | output | IDX_W | Table index for the learn request |

## Verification
The assertions check, on every cycle, the two-edge latency and index of each new request, that a stalled output holds, that input ready drops only while a request waits at the output, that an out-of-range hash never reaches the decision stage, and that one index is never forwarded on two consecutive decisions. Only the bench scenarios can show the decision itself. These cover the zero-cleared store, the 99/100 boundary for every index, a drop leaving its timestamp untouched, the 16-bit wrap, and the order and completeness of requests across a long stall. The bench checks these against a timestamp model it keeps itself.

// File: rtl/lrl_pkg.sv
package lrl_pkg;
   // Width of the time base and of every stored stamp; fixed by the function.
   localparam int TS_W = 16;

   typedef logic [TS_W-1:0] stamp_t;

   // Wrap-safe elapsed time between two stamps.
   function automatic stamp_t stamp_elapsed(input stamp_t now_v, input stamp_t then_v);
      return stamp_t'(now_v - then_v);
   endfunction
endpackage

// File: rtl/lrl_tick_counter.sv
module lrl_tick_counter
   import lrl_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick_i,
   output stamp_t now_o
);
   stamp_t count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (tick_i)
         count_q <= count_q + stamp_t'(1);
   end

   assign now_o = count_q;
endmodule

// File: rtl/lrl_stamp_store.sv
module lrl_stamp_store
   import lrl_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  stamp_t           wr_stamp_i,
   output stamp_t           rd_stamp_o
);
   stamp_t mem_q [DEPTH];
   stamp_t rd_q;
   logic   collide;

   // A read of the entry being written in the same cycle takes the new value.
   assign collide = wr_en_i && (wr_idx_i == rd_idx_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem_q[i] <= '0;
      end else if (wr_en_i) begin
         mem_q[wr_idx_i] <= wr_stamp_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else if (rd_en_i)
         rd_q <= collide ? wr_stamp_i : mem_q[rd_idx_i];
   end

   assign rd_stamp_o = rd_q;
endmodule

// File: rtl/lrl_gate.sv
module lrl_gate
   import lrl_pkg::*;
#(
   parameter int THRESH = 100
) (
   input  stamp_t now_i,
   input  stamp_t stamp_i,
   output logic   pass_o
);
   generate
      if (THRESH == 0) begin : g_open
         assign pass_o = 1'b1;
      end else begin : g_cmp
         stamp_t elapsed;
         assign elapsed = stamp_elapsed(now_i, stamp_i);
         assign pass_o  = (elapsed >= stamp_t'(THRESH));
      end
   endgenerate
endmodule

// File: rtl/lrl_out_skid.sv
module lrl_out_skid #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] push_data_i,
   input  logic         out_ready_i,
   output logic         out_valid_o,
   output logic [W-1:0] out_data_o,
   output logic         full_o
);
   logic         out_v_q, skid_v_q;
   logic [W-1:0] out_d_q, skid_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v_q  <= 1'b0;
         out_d_q  <= '0;
         skid_v_q <= 1'b0;
         skid_d_q <= '0;
      end else if (!out_v_q || out_ready_i) begin
         if (skid_v_q) begin
            out_v_q  <= 1'b1;
            out_d_q  <= skid_d_q;
            skid_v_q <= 1'b0;
         end else begin
            out_v_q <= push_i;
            if (push_i)
               out_d_q <= push_data_i;
         end
      end else if (push_i) begin
         skid_v_q <= 1'b1;
         skid_d_q <= push_data_i;
      end
   end

   assign out_valid_o = out_v_q;
   assign out_data_o  = out_d_q;
   assign full_o      = skid_v_q;
endmodule

// File: rtl/flow_learn_throttle.sv
module flow_learn_throttle
   import lrl_pkg::*;
#(
   parameter int HASH_W    = 16,
   parameter int DEPTH     = 256,
   parameter int TICK_RATE = 1000,
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int THRESH   = TICK_RATE / 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              in_valid_i,
   input  logic [HASH_W-1:0] in_hash_i,
   output logic              in_ready_o,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [IDX_W-1:0]  out_idx_o
);
   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (HASH_W < IDX_W) begin : g_bad_hash
         $error("HASH_W must cover the table index");
      end
      if (THRESH >= (1 << TS_W)) begin : g_bad_thresh
         $error("threshold must fit in the stamp width");
      end
   endgenerate

   stamp_t           now;
   stamp_t           rd_stamp;
   logic             in_range;
   logic             adv;
   logic             accept;
   logic             s1_valid;
   logic [IDX_W-1:0] s1_idx;
   logic             pass;
   logic             push;
   logic             skid_full;
   logic [IDX_W-1:0] in_idx;

   assign in_idx = in_hash_i[IDX_W-1:0];

   generate
      if (HASH_W > IDX_W) begin : g_range_chk
         assign in_range = ~|in_hash_i[HASH_W-1:IDX_W];
      end else begin : g_range_all
         assign in_range = 1'b1;
      end
   endgenerate

   // The decision stage moves only when the skid slot is free.
   assign adv        = !skid_full;
   assign in_ready_o = adv;
   assign accept     = in_valid_i && adv;

   lrl_tick_counter u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .now_o  (now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_idx   <= '0;
      end else if (adv) begin
         s1_valid <= accept && in_range;
         s1_idx   <= in_idx;
      end
   end

   lrl_gate #(.THRESH(THRESH)) u_gate (
      .now_i   (now),
      .stamp_i (rd_stamp),
      .pass_o  (pass)
   );

   assign push = s1_valid && adv && pass;

   lrl_stamp_store #(.DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en_i    (accept && in_range),
      .rd_idx_i   (in_idx),
      .wr_en_i    (push),
      .wr_idx_i   (s1_idx),
      .wr_stamp_i (now),
      .rd_stamp_o (rd_stamp)
   );

   lrl_out_skid #(.W(IDX_W)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_data_i (s1_idx),
      .out_ready_i (out_ready_i),
      .out_valid_o (out_valid_o),
      .out_data_o  (out_idx_o),
      .full_o      (skid_full)
   );
endmodule

// File: rtl/flow_learn_throttle_chk.sv
module flow_learn_throttle_chk #(
   parameter int HASH_W = 16,
   parameter int IDX_W  = 8,
   parameter int THRESH = 100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid_i,
   input logic [HASH_W-1:0] in_hash_i,
   input logic              in_ready_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic [IDX_W-1:0]  out_idx_o,
   input logic              in_range,
   input logic              s1_valid,
   input logic [IDX_W-1:0]  s1_idx,
   input logic              push
);
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o, 2));

   a_r9_index: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid_o) |-> out_idx_o == $past(in_hash_i[IDX_W-1:0], 2));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_idx_o));

   a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready_o |-> out_valid_o);

   a_r2_discard: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i && in_ready_o && !in_range |=> !s1_valid);

   a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (THRESH > 1) && push && $past(push) |-> s1_idx != $past(s1_idx));
endmodule

bind flow_learn_throttle flow_learn_throttle_chk #(
   .HASH_W (HASH_W),
   .IDX_W  (IDX_W),
   .THRESH (THRESH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid_i  (in_valid_i),
   .in_hash_i   (in_hash_i),
   .in_ready_o  (in_ready_o),
   .out_valid_o (out_valid_o),
   .out_ready_i (out_ready_i),
   .out_idx_o   (out_idx_o),
   .in_range    (in_range),
   .s1_valid    (s1_valid),
   .s1_idx      (s1_idx),
   .push        (push)
);

// File: tb/flow_learn_throttle_bench.sv
module flow_learn_throttle_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HASH_W     = 8;
   localparam int DEPTH      = 16;
   localparam int TICK_RATE  = 1000;
   localparam int IDX_W      = 4;
   localparam int THR        = TICK_RATE / 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              in_valid = 1'b0;
   logic [HASH_W-1:0] in_hash = '0;
   logic              in_ready;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [IDX_W-1:0]  out_idx;

   int          errors = 0;
   int          checks = 0;
   int          now_t  = 0;
   logic [15:0] model [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   flow_learn_throttle #(
      .HASH_W(HASH_W), .DEPTH(DEPTH), .TICK_RATE(TICK_RATE)
   ) u_flow_learn_throttle (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .in_valid_i(in_valid), .in_hash_i(in_hash), .in_ready_o(in_ready),
      .out_valid_o(out_valid), .out_ready_i(out_ready), .out_idx_o(out_idx)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic advance(input int n);
      if (n > 0) begin
         @(negedge clk) tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
         now_t += n;
      end
   endtask

   // Expected outcome from the requirement arithmetic (R4, R5, R7).
   function automatic bit model_pass(input int h);
      logic [15:0] el;
      if (h >= DEPTH) return 1'b0;
      el = 16'(now_t) - model[h];
      return (el >= 16'(THR));
   endfunction

   task automatic send(input int h, input string tag);
      bit exp;
      exp = model_pass(h);
      @(negedge clk) in_valid = 1'b1; in_hash = HASH_W'(h);
      @(negedge clk) in_valid = 1'b0;
      check(out_valid == 1'b0, "R9 no early request", int'(out_valid), 0);
      @(negedge clk);
      check(out_valid == exp, tag, int'(out_valid), int'(exp));
      if (exp) begin
         check(out_idx == IDX_W'(h), tag, int'(out_idx), h);
         model[h] = 16'(now_t);
      end
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
   end

   initial begin
      int got [3];
      int ng;
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

      // R6: zero-cleared store, time 0 then 99 -> drop
      for (int i = 0; i < DEPTH; i++) send(i, "R6 drop at time 0");
      advance(THR - 1);
      send(0, "R6 drop below threshold");
      advance(1);
      // R2: every out-of-range hash dropped
      for (int h = DEPTH; h < 256; h++) send(h, "R2 out of range dropped");
      // R6/R5/R3: every index passes once the counter reaches the threshold
      for (int i = 0; i < DEPTH; i++) send(i, "R6 first pass at threshold");
      send(5, "R5 repeat drops after stamp update");
      // R4: boundary sweep 99 then 100
      advance(THR - 1);
      for (int i = 0; i < DEPTH; i++) send(i, "R4 drop at elapsed 99");
      advance(1);
      for (int i = 0; i < DEPTH; i++) send(i, "R4 pass at elapsed 100");
      // R2: out-of-range alias leaves the stamp untouched
      advance(THR);
      send(DEPTH + 7, "R2 alias dropped");
      send(7, "R2 alias left stamp intact");

      // R8: same index on consecutive cycles
      advance(2 * THR);
      @(negedge clk) in_valid = 1'b1; in_hash = 8'd11;
      @(negedge clk);
      @(negedge clk) in_valid = 1'b0;
      check(out_valid == 1'b1 && out_idx == 4'd11, "R8 first of pair passes", int'(out_idx), 11);
      model[11] = 16'(now_t);
      @(negedge clk);
      check(out_valid == 1'b0, "R8 second of pair dropped", int'(out_valid), 0);

      // R10: stall with skid buffer
      advance(2 * THR);
      out_ready = 1'b0;
      @(negedge clk) in_valid = 1'b1; in_hash = 8'd1;
      @(negedge clk) in_hash = 8'd2;
      @(negedge clk) in_hash = 8'd3;
      @(negedge clk) in_valid = 1'b0;
      check(in_ready == 1'b0, "R10 ready low when skid full", int'(in_ready), 0);
      for (int k = 0; k < 3; k++) begin
         check(out_valid == 1'b1 && out_idx == 4'd1, "R10 output held", int'(out_idx), 1);
         @(negedge clk);
      end
      out_ready = 1'b1;
      ng = 0;
      for (int k = 0; k < 6; k++) begin
         if (out_valid) begin
            if (ng < 3) got[ng] = int'(out_idx);
            ng++;
         end
         @(negedge clk);
      end
      check(ng == 3, "R10 request count after stall", ng, 3);
      for (int k = 0; k < 3; k++)
         check(got[k] == k + 1, "R10 order after stall", got[k], k + 1);
      for (int k = 1; k <= 3; k++) model[k] = 16'(now_t);
      check(in_ready == 1'b1, "R10 ready back after drain", int'(in_ready), 1);

      // R7/R3: across the 16-bit wrap
      advance(65530 - now_t);
      send(9, "R7 pass before wrap");
      advance(60);
      send(9, "R7 drop across wrap elapsed 60");
      advance(40);
      send(9, "R7 pass across wrap elapsed 100");

      report();
      $finish;
   end
endmodule